// File: doc/BRIEF.md
# Four-bit Mode-Selectable ALU Slice

This block is one slice of a wider arithmetic unit. Two operand words, a four-bit function code and a mode bit choose one of 32 operations. Sixteen of them are bitwise logic functions with no carry between bit positions. The other sixteen are arithmetic functions, and the carry input adds one to each of them. For chaining, the slice provides a ripple carry output. It also provides a group propagate and a group generate, so that an external lookahead unit can combine several slices without waiting on the carry input. A flag reports when every result bit is one. In the subtract function this flag acts as an equality compare.

The operand datapath is combinational. Every output is captured in a register, so a result appears one clock after its inputs are sampled. A synchronous active-high reset clears all outputs. The operand width is a parameter with a default of 4.

Top module: `mslice_alu`

## Requirements
- R1: While `rst` is sampled high on a rising edge, every output becomes 0. Otherwise each output shows the function of the inputs sampled on the previous rising edge.
- R2: With `logic_mode`=1, each result bit depends only on the same bit of A and B. Listed as fsel: function, the map is: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 all zeros, 0100 ~(A&B), 0101 ~B, 0110 ~(A^B), 0111 A&~B, 1000 ~A|B, 1001 A^B, 1010 B, 1011 A&B, 1100 all ones, 1101 A|~B, 1110 A|B, 1111 A.
- R3: With `logic_mode`=0, the result is (X + Y + c_in) mod 2^W. Here X = A | (B & fsel[0]) | (~B & fsel[1]) and Y = A & ((B & fsel[3]) | (~B & fsel[2])), with fsel[0] the least significant select bit.
- R4: In arithmetic mode, raising `c_in` adds exactly one to the result of any selected function.
- R5: Code 0110 in arithmetic mode gives A-B-1 with `c_in`=0 and A-B with `c_in`=1. With `c_in`=1, `c_out` is 1 exactly when A >= B (no borrow).
- R6: Code 1001 gives A+B+c_in in arithmetic mode, with `c_out` as the bit above the result. In logic mode the same code gives A^B.
- R7: `grp_prop` is the AND of all X bits. `grp_gen` is the carry out of X+Y with a zero carry in. Both depend only on A, B and fsel, never on `c_in` or `logic_mode`.
- R8: `c_out` equals `grp_gen | (grp_prop & c_in)` in both modes.
- R9: `all_ones` is 1 exactly when every bit of `f_out` is 1. With code 0110, arithmetic mode and `c_in`=0, this means A equals B.
- R10: In logic mode, `c_in` has no effect on `f_out`, and code 0011 gives all zeros.
- R11: Code 1100 in arithmetic mode with `c_in`=0 gives A+A, which is A shifted one place toward the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| fsel | input | 4 | Function code |
| logic_mode | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| c_in | input | 1 | Carry input, active high |
| f_out | output | W | Registered result |
| c_out | output | 1 | Registered ripple carry output |
| grp_prop | output | 1 | Registered group propagate |
| grp_gen | output | 1 | Registered group generate |
| all_ones | output | 1 | Registered all-result-bits-one flag |

## Verification
The main sweep applies every combination of A, B, function code, mode and carry input. This separates the 32 operations and catches any bit whose carry leaks across positions in logic mode. Directed vectors cover specific boundaries: subtraction at A=B and across the borrow, addition that overflows to the carry output, A+A shifting a one out of the top bit, and the same function applied with each carry input value. These show the +1 effect of the carry input in arithmetic mode and its absence in logic mode. Pairs that differ only in `c_in` also tell apart a group propagate or generate that wrongly depends on the carry from one that does not.

// File: rtl/mslice_pkg.sv
package mslice_pkg;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] fsel_t;

  localparam fsel_t LF_NOT_A   = 4'b0000;
  localparam fsel_t LF_NOR     = 4'b0001;
  localparam fsel_t LF_NA_AND_B = 4'b0010;
  localparam fsel_t LF_ZERO    = 4'b0011;
  localparam fsel_t LF_NAND    = 4'b0100;
  localparam fsel_t LF_NOT_B   = 4'b0101;
  localparam fsel_t LF_XNOR    = 4'b0110;
  localparam fsel_t LF_A_AND_NB = 4'b0111;
  localparam fsel_t LF_NA_OR_B = 4'b1000;
  localparam fsel_t LF_XOR     = 4'b1001;
  localparam fsel_t LF_PASS_B  = 4'b1010;
  localparam fsel_t LF_AND     = 4'b1011;
  localparam fsel_t LF_ONE     = 4'b1100;
  localparam fsel_t LF_A_OR_NB = 4'b1101;
  localparam fsel_t LF_OR      = 4'b1110;
  localparam fsel_t LF_PASS_A  = 4'b1111;
endpackage

// File: rtl/mslice_xy_gen.sv
module mslice_xy_gen
  import mslice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fsel_t        fsel,
  output logic [W-1:0] x,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign x[i] = a[i] | (b[i] & fsel[0]) | (~b[i] & fsel[1]);
    assign y[i] = a[i] & ((b[i] & fsel[3]) | (~b[i] & fsel[2]));
  end
endmodule

// File: rtl/mslice_lookahead.sv
module mslice_lookahead #(
  parameter int W = 4
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  input  logic         cin,
  output logic [W-1:0] carry,
  output logic         grp_p,
  output logic         grp_g,
  output logic         cout
);
  logic [W-1:0] gchain;
  logic [W-1:0] pchain;

  assign carry[0]  = cin;
  assign gchain[0] = gen[0];
  assign pchain[0] = prop[0];

  for (genvar i = 1; i < W; i++) begin : g_chain
    assign carry[i]  = gen[i-1] | (prop[i-1] & carry[i-1]);
    assign gchain[i] = gen[i] | (prop[i] & gchain[i-1]);
    assign pchain[i] = prop[i] & pchain[i-1];
  end

  assign grp_g = gchain[W-1];
  assign grp_p = pchain[W-1];
  assign cout  = grp_g | (grp_p & cin);
endmodule

// File: rtl/mslice_fmux.sv
module mslice_fmux
  import mslice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fsel_t        fsel,
  input  logic         mode,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] carry,
  output logic [W-1:0] f
);
  logic [W-1:0] logic_f;
  logic [W-1:0] arith_f;

  always_comb begin
    unique case (fsel)
      LF_NOT_A:    logic_f = ~a;
      LF_NOR:      logic_f = ~(a | b);
      LF_NA_AND_B: logic_f = ~a & b;
      LF_ZERO:     logic_f = '0;
      LF_NAND:     logic_f = ~(a & b);
      LF_NOT_B:    logic_f = ~b;
      LF_XNOR:     logic_f = ~(a ^ b);
      LF_A_AND_NB: logic_f = a & ~b;
      LF_NA_OR_B:  logic_f = ~a | b;
      LF_XOR:      logic_f = a ^ b;
      LF_PASS_B:   logic_f = b;
      LF_AND:      logic_f = a & b;
      LF_ONE:      logic_f = '1;
      LF_A_OR_NB:  logic_f = a | ~b;
      LF_OR:       logic_f = a | b;
      default:     logic_f = a;
    endcase
  end

  assign arith_f = x ^ y ^ carry;
  assign f       = mode ? logic_f : arith_f;
endmodule

// File: rtl/mslice_alu.sv
module mslice_alu
  import mslice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  input  logic [SEL_W-1:0] fsel,
  input  logic             logic_mode,
  input  logic             c_in,
  output logic [W-1:0]     f_out,
  output logic             c_out,
  output logic             grp_prop,
  output logic             grp_gen,
  output logic             all_ones
);
  logic [W-1:0] x_term;
  logic [W-1:0] y_term;
  logic [W-1:0] carry;
  logic [W-1:0] f_nxt;
  logic         gp_nxt;
  logic         gg_nxt;
  logic         co_nxt;

  mslice_xy_gen #(.W(W)) u_xy (
    .a(a_in), .b(b_in), .fsel(fsel), .x(x_term), .y(y_term)
  );

  mslice_lookahead #(.W(W)) u_cla (
    .prop(x_term), .gen(y_term), .cin(c_in), .carry(carry),
    .grp_p(gp_nxt), .grp_g(gg_nxt), .cout(co_nxt)
  );

  mslice_fmux #(.W(W)) u_mux (
    .a(a_in), .b(b_in), .fsel(fsel), .mode(logic_mode),
    .x(x_term), .y(y_term), .carry(carry), .f(f_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f_out    <= '0;
      c_out    <= 1'b0;
      grp_prop <= 1'b0;
      grp_gen  <= 1'b0;
      all_ones <= 1'b0;
    end else begin
      f_out    <= f_nxt;
      c_out    <= co_nxt;
      grp_prop <= gp_nxt;
      grp_gen  <= gg_nxt;
      all_ones <= &f_nxt;
    end
  end
endmodule

// File: rtl/mslice_alu_chk.sv
module mslice_alu_chk
  import mslice_pkg::*;
#(
  parameter int W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     a_in,
  input logic [W-1:0]     b_in,
  input logic [SEL_W-1:0] fsel,
  input logic             logic_mode,
  input logic             c_in,
  input logic [W-1:0]     f_out,
  input logic             c_out,
  input logic             grp_prop,
  input logic             grp_gen,
  input logic             all_ones
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (f_out == '0 && !c_out && !grp_prop && !grp_gen && !all_ones));

  a_r5_subtract: assert property (@(posedge clk) disable iff (rst)
    (!logic_mode && fsel == 4'b0110 && c_in) |=>
      (f_out == W'($past(a_in) - $past(b_in)) && c_out == ($past(a_in) >= $past(b_in))));

  a_r6_add: assert property (@(posedge clk) disable iff (rst)
    (!logic_mode && fsel == 4'b1001) |=>
      ({c_out, f_out} == ({1'b0, $past(a_in)} + {1'b0, $past(b_in)} + (W+1)'($past(c_in)))));

  a_r6_xor: assert property (@(posedge clk) disable iff (rst)
    (logic_mode && fsel == 4'b1001) |=> (f_out == ($past(a_in) ^ $past(b_in))));

  a_r7_group: assert property (@(posedge clk) disable iff (rst)
    (fsel == 4'b1001) |=>
      (grp_prop == (&($past(a_in) | $past(b_in))) &&
       grp_gen == ((({1'b0, $past(a_in)} + {1'b0, $past(b_in)}) >> W) != 0)));

  a_r8_carry_out: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (c_out == (grp_gen | (grp_prop & $past(c_in)))));

  a_r9_all_ones: assert property (@(posedge clk) disable iff (rst)
    all_ones == (&f_out));

  a_r10_zero: assert property (@(posedge clk) disable iff (rst)
    (logic_mode && fsel == 4'b0011) |=> (f_out == '0 && !all_ones));
endmodule

bind mslice_alu mslice_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .fsel(fsel),
  .logic_mode(logic_mode), .c_in(c_in), .f_out(f_out), .c_out(c_out),
  .grp_prop(grp_prop), .grp_gen(grp_gen), .all_ones(all_ones)
);

// File: tb/sim_mslice_alu.sv
module sim_mslice_alu;
  typedef struct packed {
    logic [3:0] f;
    logic       c;
    logic       p;
    logic       g;
    logic       e;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a_in = '0;
  logic [3:0] b_in = '0;
  logic [3:0] fsel = '0;
  logic       logic_mode = 1'b0;
  logic       c_in = 1'b0;
  logic [3:0] f_out;
  logic       c_out, grp_prop, grp_gen, all_ones;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t  expq[$];
  string tagq[$];

  always #5 clk = ~clk;

  mslice_alu #(.W(4)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .fsel(fsel),
    .logic_mode(logic_mode), .c_in(c_in), .f_out(f_out), .c_out(c_out),
    .grp_prop(grp_prop), .grp_gen(grp_gen), .all_ones(all_ones)
  );

  function automatic exp_t model(input logic [3:0] a, b, s, input logic m, cin);
    exp_t r;
    logic [3:0] x, y, lf;
    logic [4:0] t0, t1;
    case (s)
      4'b0000: begin x = a;       y = 4'h0;   end
      4'b0001: begin x = a | b;   y = 4'h0;   end
      4'b0010: begin x = a | ~b;  y = 4'h0;   end
      4'b0011: begin x = 4'hF;    y = 4'h0;   end
      4'b0100: begin x = a;       y = a & ~b; end
      4'b0101: begin x = a | b;   y = a & ~b; end
      4'b0110: begin x = a | ~b;  y = a & ~b; end
      4'b0111: begin x = 4'hF;    y = a & ~b; end
      4'b1000: begin x = a;       y = a & b;  end
      4'b1001: begin x = a | b;   y = a & b;  end
      4'b1010: begin x = a | ~b;  y = a & b;  end
      4'b1011: begin x = 4'hF;    y = a & b;  end
      4'b1100: begin x = a;       y = a;      end
      4'b1101: begin x = a | b;   y = a;      end
      4'b1110: begin x = a | ~b;  y = a;      end
      default: begin x = 4'hF;    y = a;      end
    endcase
    case (s)
      4'b0000: lf = ~a;
      4'b0001: lf = ~(a | b);
      4'b0010: lf = ~a & b;
      4'b0011: lf = 4'h0;
      4'b0100: lf = ~(a & b);
      4'b0101: lf = ~b;
      4'b0110: lf = ~(a ^ b);
      4'b0111: lf = a & ~b;
      4'b1000: lf = ~a | b;
      4'b1001: lf = a ^ b;
      4'b1010: lf = b;
      4'b1011: lf = a & b;
      4'b1100: lf = 4'hF;
      4'b1101: lf = a | ~b;
      4'b1110: lf = a | b;
      default: lf = a;
    endcase
    t0  = {1'b0, x} + {1'b0, y};
    t1  = t0 + {4'h0, cin};
    r.f = m ? lf : t1[3:0];
    r.p = &x;
    r.g = t0[4];
    r.c = t1[4];
    r.e = &r.f;
    return r;
  endfunction

  task automatic drive(input logic [3:0] a, b, s, input logic m, cin, input string tag);
    @(negedge clk);
    a_in = a; b_in = b; fsel = s; logic_mode = m; c_in = cin;
    expq.push_back(model(a, b, s, m, cin));
    tagq.push_back(tag);
  endtask

  task automatic drive_exp(input logic [3:0] a, b, s, input logic m, cin,
                           input exp_t e, input string tag);
    @(negedge clk);
    a_in = a; b_in = b; fsel = s; logic_mode = m; c_in = cin;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  // monitor: pops one expected item per cycle after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expq.size() > 0) begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        checks++;
        if ({f_out, c_out, grp_prop, grp_gen, all_ones} != e) begin
          errors++;
          $display("FAIL %s f=%h c=%b p=%b g=%b e=%b exp f=%h c=%b p=%b g=%b e=%b",
                   t, f_out, c_out, grp_prop, grp_gen, all_ones, e.f, e.c, e.p, e.g, e.e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with active inputs
    a_in = 4'hF; b_in = 4'hF; fsel = 4'b1100; logic_mode = 1'b1; c_in = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({f_out, c_out, grp_prop, grp_gen, all_ones} != 8'h00) begin
      errors++;
      $display("FAIL R1 reset outputs=%h exp=00", {f_out, c_out, grp_prop, grp_gen, all_ones});
    end
    @(negedge clk);
    rst = 1'b0;

    // R4: carry in adds one (pass A: 5 -> 5, 6)
    drive_exp(4'h5, 4'h9, 4'b0000, 1'b0, 1'b0, '{f:4'h5, c:1'b0, p:1'b0, g:1'b0, e:1'b0}, "R4");
    drive_exp(4'h5, 4'h9, 4'b0000, 1'b0, 1'b1, '{f:4'h6, c:1'b0, p:1'b0, g:1'b0, e:1'b0}, "R4");
    // R5: subtract 9-3 with and without carry; underflow 3-9 borrows
    drive(4'h9, 4'h3, 4'b0110, 1'b0, 1'b1, "R5");
    drive(4'h9, 4'h3, 4'b0110, 1'b0, 1'b0, "R5");
    drive(4'h3, 4'h9, 4'b0110, 1'b0, 1'b1, "R5");
    // R9: equal operands give all ones in subtract without carry
    drive(4'h7, 4'h7, 4'b0110, 1'b0, 1'b0, "R9");
    drive(4'h7, 4'h6, 4'b0110, 1'b0, 1'b0, "R9");
    // R6: add overflow 9+8 -> 1 carry 1; logic XOR
    drive_exp(4'h9, 4'h8, 4'b1001, 1'b0, 1'b0, '{f:4'h1, c:1'b1, p:1'b0, g:1'b1, e:1'b0}, "R6");
    drive(4'h9, 4'h8, 4'b1001, 1'b1, 1'b0, "R6");
    // R7: group outputs unchanged by carry in; R8 carry out via propagate
    drive(4'hF, 4'h0, 4'b1001, 1'b0, 1'b0, "R7");
    drive(4'hF, 4'h0, 4'b1001, 1'b0, 1'b1, "R8");
    // R10: logic zero ignores carry in
    drive(4'hF, 4'hA, 4'b0011, 1'b1, 1'b1, "R10");
    drive(4'h6, 4'h3, 4'b0110, 1'b1, 1'b1, "R10");
    // R11: A+A shift, top bit into carry
    drive_exp(4'hB, 4'h0, 4'b1100, 1'b0, 1'b0, '{f:4'h6, c:1'b1, p:1'b0, g:1'b1, e:1'b0}, "R11");

    // exhaustive sweep over both modes, all codes, operands and carries
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            for (int ci = 0; ci < 2; ci++)
              drive(4'(a), 4'(b), 4'(s), 1'(m), 1'(ci),
                    (m != 0) ? "R2 R7 R8 R9 R10" : "R3 R4 R7 R8 R9");

    repeat (4) @(posedge clk);
    #3;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule